// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Slave

This block is a slave on a two-wire serial bus (SCL/SDA, standard mode, up to 100 kbit/s) that holds a bank of seven 8-bit control registers for a host. The bus lines are brought into a fast system clock through synchronizers. START and STOP are recovered as SDA edges seen while SCL is high. SDA is driven as an open-drain line: the block only ever pulls it low.

Access is by whole-bank sequential frames and nothing else. A write frame carries the write address, then two header bytes that are acknowledged and thrown away, then data that fills register 0, register 1 and so on upward. A read frame carries the read address. The slave answers with a count byte and then with registers 0 to 6. There is no register pointer, so every frame starts at register 0. The register contents drive the rest of the chip through a flat output vector.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, SDA is released and the registers hold reg0=0x00, reg1=0x0F, reg2=0xFF, reg3=0xFF, reg4=0xFF, reg5=0xEF, reg6=0x06. Register n occupies bits [8n+7:8n] of `regs_o`.
- R2: Only the 7-bit address 0x69 is acknowledged. On the wire this is 0xD2 for a write and 0xD3 for a read, with the direction bit sent last. Any other address is not acknowledged, and the slave ignores the bus until the next START.
- R3: In a write frame, the first two bytes after the address are acknowledged and their values are discarded. Each following byte, sent MSB first, is stored in register 0, 1, 2 and so on in that order, and each is acknowledged.
- R4: A STOP after any complete data byte ends the write. Registers already received keep their new values, and later registers keep their old ones.
- R5: Data bytes beyond the seventh are acknowledged and do not change any register.
- R6: A read frame returns a count byte of 7 and then registers 0 through 6, each MSB first. The host acknowledges each byte.
- R7: When the host does not acknowledge a read byte, transmission ends. SDA stays released for any further clocks until the next START.
- R8: Read bytes requested after register 6 come back as 0xFF, because SDA is left released.
- R9: A repeated START inside a frame restarts address reception. Register values written earlier in that frame are kept.
- R10: The slave only starts pulling SDA low while SCL is low.
- R11: Registers change only when a write data byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 56 | Register bank, register n at bits [8n+7:8n] |

## Verification
The case hardest to reach from the ports is a repeated START that arrives after some data bytes of a write have already been committed. The register update and the restart of address reception then overlap within one frame. The bench holds a write frame open without a STOP, issues a fresh START on the bus, and sends a shorter second write. Register 0 must take the new value and register 1 must keep the value from the first write. A second case that is hard to reach is a host NACK in the middle of a read: the host keeps clocking afterwards and must read back a released line.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;

  // idle bus is high, so reset to ones to avoid a false START
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
    end
  end

  assign scl_o = scl_ff[STAGES-1];
  assign sda_o = sda_ff[STAGES-1];
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NREG = 7,
  parameter int DW = 8,
  parameter int IW = 3,
  parameter logic [NREG*DW-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) mem[k] <= RST_VAL[k*DW +: DW];
    end else if (we_i) begin
      for (int k = 0; k < NREG; k++)
        if (idx_i == IW'(k)) mem[k] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int NREG        = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SKIP_BYTES  = 2,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69,
  parameter logic [DW-1:0] FILL_BYTE = 8'hFF,
  parameter logic [NREG*DW-1:0] RST_VAL = 56'h06EF_FFFF_FF0F_00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int BCW = $clog2(DW + 1);
  localparam int IW  = $clog2(NREG + 1);
  localparam int CW  = $clog2(NREG + SKIP_BYTES + 1);
  localparam logic [BCW-1:0] BIT_LAST   = BCW'(DW);
  localparam logic [CW-1:0]  SKIP_C     = CW'(SKIP_BYTES);
  localparam logic [CW-1:0]  CNT_MAX    = CW'(NREG + SKIP_BYTES);
  localparam logic [IW-1:0]  RD_MAX     = IW'(NREG);
  localparam logic [DW-1:0]  COUNT_BYTE = DW'(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .scl_o(scl_s), .sda_o(sda_s)
  );

  smb_cond_det u_det (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_cfg_pkg::smb_state_e state_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [DW-1:0]  shift_q, tx_q, rd_byte;
  logic [CW-1:0]  byte_cnt_q, wsub;
  logic [IW-1:0]  rd_idx_q;
  logic           oe_q, rw_q, wr_en;

  assign wsub  = byte_cnt_q - SKIP_C;
  assign wr_en = (state_q == S_WDATA) && scl_fall && (bit_cnt_q == BIT_LAST) &&
                 (byte_cnt_q >= SKIP_C) && (byte_cnt_q < CNT_MAX);

  smb_reg_bank #(.NREG(NREG), .DW(DW), .IW(IW), .RST_VAL(RST_VAL)) u_bank (
    .clk_i, .rst_ni, .we_i(wr_en), .idx_i(wsub[IW-1:0]),
    .wdata_i(shift_q), .regs_o
  );

  always_comb begin
    rd_byte = FILL_BYTE;
    for (int k = 0; k < NREG; k++)
      if (rd_idx_q == IW'(k)) rd_byte = regs_o[k*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      tx_q       <= '1;
      byte_cnt_q <= '0;
      rd_idx_q   <= '0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
    end else if (start_det) begin
      state_q   <= S_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q <= S_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: ;
        S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shift_q   <= {shift_q[DW-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall && bit_cnt_q == BIT_LAST) begin
            if (state_q == S_WDATA) begin
              oe_q    <= 1'b1;
              state_q <= S_WACK;
              if (byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + 1'b1;
            end else if (shift_q[DW-1:1] == DEV_ADDR) begin
              oe_q    <= 1'b1;
              rw_q    <= shift_q[0];
              state_q <= S_AACK;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            rd_idx_q   <= '0;
            if (rw_q) begin
              tx_q    <= COUNT_BYTE;
              oe_q    <= ~COUNT_BYTE[DW-1];
              state_q <= S_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= S_WDATA;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt_q == BIT_LAST) begin
              oe_q    <= 1'b0;
              state_q <= S_RACK;
            end else begin
              oe_q <= ~tx_q[DW-2];
              tx_q <= {tx_q[DW-2:0], 1'b1};
            end
          end
        end
        S_RACK: begin
          if (scl_rise && sda_s) begin
            state_q <= S_IDLE;  // host NACK: stay off the bus until START
          end else if (scl_fall) begin
            tx_q      <= rd_byte;
            oe_q      <= ~rd_byte[DW-1];
            bit_cnt_q <= '0;
            state_q   <= S_RDATA;
            if (rd_idx_q != RD_MAX) rd_idx_q <= rd_idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 7,
  parameter int DW = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sda_oe_i,
  input logic               scl_s_i,
  input logic [NREG*DW-1:0] regs_i,
  input smb_state_e         state_i,
  input logic               start_i,
  input logic               stop_i,
  input logic [DW-2:0]      addr_i
);
  assert_drive_low_scl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> $past(!scl_s_i));

  assert_regs_only_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> $past(state_i == S_WDATA));

  assert_idle_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_IDLE) |-> !sda_oe_i);

  assert_restart_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == S_ADDR));

  assert_addr_ack_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_AACK && sda_oe_i) |-> (addr_i == DEV_ADDR));

  assert_stop_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == S_IDLE));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .scl_s_i(scl_s),
  .regs_i(regs_o), .state_i(state_q), .start_i(start_det), .stop_i(stop_det),
  .addr_i(shift_q[DW-1:1])
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [55:0] regs_o;
  wire sda_bus = sda_h & ~sda_oe;

  always #2 clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .regs_o(regs_o)
  );

  logic [7:0] exp_regs [7];
  logic [7:0] wq [$];
  int n_checks = 0, n_fail = 0, reg_err = 0, drv_err = 0;
  bit cmp_en = 1'b0, oe_prev = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R11 continuous register model compare, R10 drive-while-SCL-low watch
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_en)
        for (int k = 0; k < 7; k++)
          if (regs_o[k*8 +: 8] !== exp_regs[k]) reg_err++;
      if (sda_oe && !oe_prev && scl_h) drv_err++;
    end
    oe_prev = sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    sda_h = b; wait_clk(Q); scl_h = 1'b1; wait_clk(2*Q); scl_h = 1'b0; wait_clk(Q);
  endtask

  task automatic recv_bit(output bit b);
    sda_h = 1'b1; wait_clk(Q); scl_h = 1'b1; wait_clk(Q);
    b = sda_bus; wait_clk(Q); scl_h = 1'b0; wait_clk(Q);
  endtask

  task automatic start_c();
    sda_h = 1'b0; wait_clk(2*Q); scl_h = 1'b0; wait_clk(Q);
  endtask

  task automatic restart_c();
    sda_h = 1'b1; wait_clk(Q); scl_h = 1'b1; wait_clk(Q);
    sda_h = 1'b0; wait_clk(Q); scl_h = 1'b0; wait_clk(Q);
  endtask

  task automatic stop_c();
    sda_h = 1'b0; wait_clk(Q); scl_h = 1'b1; wait_clk(Q); sda_h = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) cmp_en = 1'b0;  // commit window opens after the last bit
      send_bit(d[i]);
    end
    recv_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      recv_bit(b);
      d[i] = b;
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input bit restart, input bit do_stop,
                          input string req);
    bit ack;
    bit hit;
    hit = (addr == 8'hD2);
    if (restart) restart_c(); else start_c();
    send_byte(addr, ack); cmp_en = 1'b1;
    check(ack == !hit, "R2", int'(ack), int'(!hit));
    if (hit) begin
      send_byte(8'h5A, ack); cmp_en = 1'b1; check(ack == 1'b0, "R3", int'(ack), 0);
      send_byte(8'h01, ack); cmp_en = 1'b1; check(ack == 1'b0, "R3", int'(ack), 0);
      for (int k = 0; k < wq.size(); k++) begin
        send_byte(wq[k], ack);
        if (k < 7) exp_regs[k] = wq[k];
        cmp_en = 1'b1;
        check(ack == 1'b0, (k < 7) ? req : "R5", int'(ack), 0);
      end
    end else begin
      send_byte(8'h3C, ack); cmp_en = 1'b1;
      check(ack == 1'b1, "R2", int'(ack), 1);
    end
    if (do_stop) stop_c();
  endtask

  task automatic do_read(input int nb, input string req);
    bit ack;
    logic [7:0] d;
    int e;
    start_c();
    send_byte(8'hD3, ack); cmp_en = 1'b1;
    check(ack == 1'b0, "R2", int'(ack), 0);
    for (int i = 0; i < nb; i++) begin
      recv_byte(d);
      if (i == 0) e = 7;
      else if (i <= 7) e = int'(exp_regs[i-1]);
      else e = 8'hFF;
      check(int'(d) == e, (i > 7) ? "R8" : req, int'(d), e);
      send_bit(i == nb - 1);
    end
    stop_c();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    exp_regs[0] = 8'h00; exp_regs[1] = 8'h0F; exp_regs[2] = 8'hFF; exp_regs[3] = 8'hFF;
    exp_regs[4] = 8'hFF; exp_regs[5] = 8'hEF; exp_regs[6] = 8'h06;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    // R1 reset state
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
    for (int k = 0; k < 7; k++)
      check(regs_o[k*8 +: 8] == exp_regs[k], "R1", int'(regs_o[k*8 +: 8]), int'(exp_regs[k]));
    cmp_en = 1'b1;

    // R6 read of defaults
    do_read(8, "R6");

    // R3 full write, header bytes ignored
    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    do_write(8'hD2, 1'b0, 1'b1, "R3");
    do_read(8, "R3");

    // R4 partial write then STOP
    wq = '{8'hA1, 8'hB2, 8'hC3};
    do_write(8'hD2, 1'b0, 1'b1, "R4");
    do_read(8, "R4");

    // R5 overflow write, R8 read past the end
    wq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'hE8, 8'hE9, 8'hEA};
    do_write(8'hD2, 1'b0, 1'b1, "R5");
    do_read(10, "R6");

    // R2 foreign address ignored
    do_write(8'hD0, 1'b0, 1'b1, "R2");
    do_read(8, "R2");

    // R9 repeated START inside a write frame
    wq = '{8'h9A, 8'h9B};
    do_write(8'hD2, 1'b0, 1'b0, "R9");
    wq = '{8'h5C};
    do_write(8'hD2, 1'b1, 1'b1, "R9");
    do_read(8, "R9");

    // R7 host NACK mid-read, slave stays off the bus
    start_c();
    send_byte(8'hD3, ack); cmp_en = 1'b1;
    check(ack == 1'b0, "R7", int'(ack), 0);
    recv_byte(d);
    check(d == 8'd7, "R7", int'(d), 7);
    send_bit(1'b1);
    recv_byte(d);
    check(d == 8'hFF, "R7", int'(d), 8'hFF);
    check(sda_oe == 1'b0, "R7", int'(sda_oe), 0);
    send_bit(1'b1);
    stop_c();
    do_read(3, "R7");

    check(reg_err == 0, "R11", reg_err, 0);
    check(drv_err == 0, "R10", drv_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule